// File: doc/BRIEF.md
# Prioritised External Interrupt Controller

This block gathers 32 level-sensitive external interrupt lines for a machine-mode core. Each line is sampled into a pending vector and masked by a per-line enable bit. Among the lines that are both pending and enabled, an arbiter picks a winner. The winner is the line with the highest 4-bit priority. When priorities are equal, the lowest line number wins. The winner's number, multiplied by four, is readable as a "next" value. Software can add that value straight to the base of a table of 32-bit handler addresses.

A service-level stack records the priority of the interrupt currently being handled. The external pending flag is raised only when the winner's priority is strictly above that level, so a line at the same priority as the running handler cannot preempt it. The block also combines the external flag with the timer line, a local enable register and the core's global enable. From these it drives the interrupt request and the cause code. The core pulses `trap_enter` when it takes the request and `trap_return` when the handler returns.

Software reaches the block through a single-cycle select/index/data port. The enable and pending vectors appear as 16-bit windows chosen by the index. Priorities are accessed one line at a time. Other selects give the next value, the local enables, the pending flags and the current service level.

Top module: `ext_irq_ctrl`

## Requirements
- R1: The pending vector equals `irq_lines` delayed by one clock. The PENDING select (`csr_sel`=1) reads lines 16·idx to 16·idx+15 in bits 15:0. Writes to that select change nothing.
- R2: The NEXT select (`csr_sel`=3) reads the winning line number shifted left by two, with bits 1:0 zero. When no line is both pending and enabled, it reads 0x8000_0000. The value follows the lines as they change, one clock behind `irq_lines`.
- R3: The winner is the line with the highest priority. When priorities are equal, the lowest-numbered line wins.
- R4: The ENABLE select (`csr_sel`=0) reads and writes a 16-bit window. Index 0 covers lines 0–15 and index 1 covers lines 16–31. A write takes effect on the next clock. Reset clears all enables.
- R5: `ext_pend` is high only when a winner exists and its priority is strictly greater than the current service level. With no handler active, the service level is below every priority.
- R6: If `trap_enter` arrives while the cause is external, the current level is pushed and the level becomes the winner's priority. The LEVEL select (`csr_sel`=6) reads this as priority+1, and 0 when idle. Any other `trap_enter` pushes the level unchanged. `trap_return` restores the last pushed level.
- R7: `irq_req` = `mstatus_mie` AND ((`ext_pend` AND external enable) OR (`timer_irq` AND timer enable)). `cause_code` is 0x8000_000B when the external term is active, and 0x8000_0007 when only the timer term is active.
- R8: The local-enable select (`csr_sel`=4) holds the external enable at bit 11 and the timer enable at bit 7, and resets to 0. The pending-flag select (`csr_sel`=5) reads `ext_pend` at bit 11 and `timer_irq` at bit 7.
- R9: Each line has a 4-bit priority, written and read through `csr_sel`=2 with the line number as index, and resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_lines | input | 32 | Level-sensitive external interrupt lines |
| timer_irq | input | 1 | Timer interrupt line |
| mstatus_mie | input | 1 | Core's global machine interrupt enable |
| csr_en | input | 1 | Register access strobe |
| csr_wr | input | 1 | Access is a write |
| csr_sel | input | 3 | Register select |
| csr_idx | input | 5 | Window index or line number |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data, combinational from select and index |
| trap_enter | input | 1 | Core took the interrupt request this cycle |
| trap_return | input | 1 | Handler returned this cycle |
| irq_req | output | 1 | Interrupt request to the core |
| cause_code | output | 32 | Cause value for the request |
| ext_pend | output | 1 | External pending flag, allowed to preempt |

## Verification
The main pattern raises all 32 lines together at equal priority and services them one by one. Each handler reads the next value and then drops its own line. The next value must climb by four per handler, and the external flag must stay low inside each handler while the timer flag remains visible. A second pattern mixes priorities, including a tie between two lines above a lower one. It then raises a higher line during a handler, which separates a strict-greater comparison from greater-or-equal and checks nested push and restore. Further patterns write the pending window, switch the upper enable window off and on, and run the timer alone. These show that pending writes have no effect, that window writes land one clock later, and that external beats timer in the cause code.

// File: rtl/ext_irq_pkg.sv
// Package: shared constants and register-select encoding for the external
// interrupt controller. Assumes a 32-bit register data path.
package ext_irq_pkg;
    localparam int DATA_W = 32;

    typedef enum logic [2:0] {
        SEL_ENABLE  = 3'd0,
        SEL_PENDING = 3'd1,
        SEL_PRIO    = 3'd2,
        SEL_NEXT    = 3'd3,
        SEL_LOCALEN = 3'd4,
        SEL_FLAGS   = 3'd5,
        SEL_LEVEL   = 3'd6
    } csr_sel_e;

    localparam logic [DATA_W-1:0] CAUSE_EXTERNAL = 32'h8000_000B;
    localparam logic [DATA_W-1:0] CAUSE_TIMER    = 32'h8000_0007;
    localparam logic [DATA_W-1:0] NEXT_NONE      = 32'h8000_0000;
    localparam int BIT_EXT = 11;
    localparam int BIT_TMR = 7;
endpackage

// File: rtl/ext_irq_regs.sv
// Module: software-visible configuration state (enable windows, per-line
// priorities, local enables). Assumes NUM_LINES is a multiple of SLICE_W
// and that only the low index bits select an enable window.
module ext_irq_regs
    import ext_irq_pkg::*;
#(
    parameter int NUM_LINES = 32,
    parameter int SLICE_W   = 16,
    parameter int PRIO_W    = 4,
    parameter int IDX_W     = 5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [2:0]                  sel,
    input  logic [IDX_W-1:0]            idx,
    input  logic [DATA_W-1:0]           wdata,
    output logic [NUM_LINES-1:0]        enable,
    output logic [NUM_LINES*PRIO_W-1:0] prio_flat,
    output logic                        ext_en,
    output logic                        tmr_en
);
    localparam int NSLICE = NUM_LINES / SLICE_W;
    localparam int SS_W   = (NSLICE > 1) ? $clog2(NSLICE) : 1;

    logic [SS_W-1:0] slice_sel;
    assign slice_sel = SS_W'(idx);

    for (genvar s = 0; s < NSLICE; s++) begin : g_en_slice
        // Load one enable window when it is addressed by a write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                enable[s*SLICE_W +: SLICE_W] <= '0;
            else if (wr_en && sel == SEL_ENABLE && slice_sel == SS_W'(s))
                enable[s*SLICE_W +: SLICE_W] <= wdata[SLICE_W-1:0];
        end
    end

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_prio
        // Hold the priority of one line.
        always_ff @(posedge clk) begin
            if (!rst_n)
                prio_flat[i*PRIO_W +: PRIO_W] <= '0;
            else if (wr_en && sel == SEL_PRIO && idx == IDX_W'(i))
                prio_flat[i*PRIO_W +: PRIO_W] <= wdata[PRIO_W-1:0];
        end
    end

    // Local external and timer enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_en <= 1'b0;
            tmr_en <= 1'b0;
        end else if (wr_en && sel == SEL_LOCALEN) begin
            ext_en <= wdata[BIT_EXT];
            tmr_en <= wdata[BIT_TMR];
        end
    end
endmodule

// File: rtl/ext_irq_arbiter.sv
// Module: combinational winner selection. Picks the highest priority among
// requesting lines; equal priorities resolve to the lowest line number.
// Assumes requests are already masked by the enables.
module ext_irq_arbiter #(
    parameter int NUM_LINES = 32,
    parameter int PRIO_W    = 4,
    parameter int IDX_W     = 5
) (
    input  logic [NUM_LINES-1:0]        req,
    input  logic [NUM_LINES*PRIO_W-1:0] prio_flat,
    output logic                        found,
    output logic [IDX_W-1:0]            best_idx,
    output logic [PRIO_W-1:0]           best_prio
);
    // Scan upward; only a strictly higher priority replaces the holder.
    always_comb begin
        found     = 1'b0;
        best_idx  = '0;
        best_prio = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (req[i] && (!found || prio_flat[i*PRIO_W +: PRIO_W] > best_prio)) begin
                found     = 1'b1;
                best_idx  = IDX_W'(i);
                best_prio = prio_flat[i*PRIO_W +: PRIO_W];
            end
        end
    end
endmodule

// File: rtl/ext_irq_level_stack.sv
// Module: service-level register with a save stack. Level 0 means idle;
// otherwise it is priority+1. Push saves the current level and loads a new
// one; pop restores the last saved level. Assumes DEPTH covers the deepest
// strictly-increasing nesting; pushes beyond it are dropped.
module ext_irq_level_stack #(
    parameter int LVL_W = 5,
    parameter int DEPTH = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [LVL_W-1:0] push_level,
    input  logic             pop,
    output logic [LVL_W-1:0] level
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int SLOTS = 1 << CNT_W;

    logic [LVL_W-1:0] saved [SLOTS];
    logic [CNT_W-1:0] ptr;

    // Push, pop and hold of the level and its save slots.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr   <= '0;
            level <= '0;
            for (int k = 0; k < SLOTS; k++) saved[k] <= '0;
        end else if (push) begin
            if (ptr != CNT_W'(DEPTH)) begin
                saved[ptr] <= level;
                ptr        <= ptr + CNT_W'(1);
                level      <= push_level;
            end
        end else if (pop && ptr != '0) begin
            ptr   <= ptr - CNT_W'(1);
            level <= saved[ptr - CNT_W'(1)];
        end
    end
endmodule

// File: rtl/ext_irq_ctrl.sv
// Module: top of the prioritised external interrupt controller. Samples the
// lines, arbitrates, gates preemption by the service level and forms the
// request and cause for the core. Assumes the core pulses trap_enter for one
// cycle per taken request and trap_return once per handler exit.
module ext_irq_ctrl
    import ext_irq_pkg::*;
#(
    parameter int NUM_LINES = 32,
    parameter int SLICE_W   = 16,
    parameter int PRIO_W    = 4,
    localparam int IDX_W    = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_lines,
    input  logic                 timer_irq,
    input  logic                 mstatus_mie,
    input  logic                 csr_en,
    input  logic                 csr_wr,
    input  logic [2:0]           csr_sel,
    input  logic [IDX_W-1:0]     csr_idx,
    input  logic [31:0]          csr_wdata,
    output logic [31:0]          csr_rdata,
    input  logic                 trap_enter,
    input  logic                 trap_return,
    output logic                 irq_req,
    output logic [31:0]          cause_code,
    output logic                 ext_pend
);
    localparam int LVL_W  = PRIO_W + 1;
    localparam int DEPTH  = (1 << PRIO_W) + 1;
    localparam int NSLICE = NUM_LINES / SLICE_W;
    localparam int SS_W   = (NSLICE > 1) ? $clog2(NSLICE) : 1;

    logic [NUM_LINES-1:0]        pend_q;
    logic [NUM_LINES-1:0]        enable;
    logic [NUM_LINES*PRIO_W-1:0] prio_flat;
    logic                        ext_en, tmr_en;
    logic                        found;
    logic [IDX_W-1:0]            best_idx;
    logic [PRIO_W-1:0]           best_prio;
    logic [LVL_W-1:0]            level;
    logic [LVL_W-1:0]            win_level;
    logic [LVL_W-1:0]            push_level;
    logic                        take_ext, take_tmr;
    logic [SS_W-1:0]             slice_sel;

    // Pending follows the lines; software cannot write it.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= irq_lines;
    end

    ext_irq_regs #(
        .NUM_LINES(NUM_LINES), .SLICE_W(SLICE_W), .PRIO_W(PRIO_W), .IDX_W(IDX_W)
    ) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(csr_en && csr_wr), .sel(csr_sel),
        .idx(csr_idx), .wdata(csr_wdata), .enable(enable), .prio_flat(prio_flat),
        .ext_en(ext_en), .tmr_en(tmr_en)
    );

    ext_irq_arbiter #(
        .NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W), .IDX_W(IDX_W)
    ) arb_i (
        .req(pend_q & enable), .prio_flat(prio_flat), .found(found),
        .best_idx(best_idx), .best_prio(best_prio)
    );

    ext_irq_level_stack #(.LVL_W(LVL_W), .DEPTH(DEPTH)) lvl_i (
        .clk(clk), .rst_n(rst_n), .push(trap_enter), .push_level(push_level),
        .pop(trap_return && !trap_enter), .level(level)
    );

    // Preemption gate, request and cause formation.
    always_comb begin
        win_level  = LVL_W'(best_prio) + LVL_W'(1);
        ext_pend   = found && (win_level > level);
        take_ext   = ext_pend && ext_en;
        take_tmr   = timer_irq && tmr_en;
        irq_req    = mstatus_mie && (take_ext || take_tmr);
        cause_code = take_ext ? CAUSE_EXTERNAL : (take_tmr ? CAUSE_TIMER : '0);
        push_level = take_ext ? win_level : level;
    end

    assign slice_sel = SS_W'(csr_idx);

    // Read multiplexer over the register selects.
    always_comb begin
        csr_rdata = '0;
        case (csr_sel)
            SEL_ENABLE:  csr_rdata = 32'(enable[slice_sel*SLICE_W +: SLICE_W]);
            SEL_PENDING: csr_rdata = 32'(pend_q[slice_sel*SLICE_W +: SLICE_W]);
            SEL_PRIO:    csr_rdata = 32'(prio_flat[csr_idx*PRIO_W +: PRIO_W]);
            SEL_NEXT:    csr_rdata = found ? 32'({best_idx, 2'b00}) : NEXT_NONE;
            SEL_LOCALEN: begin
                csr_rdata[BIT_EXT] = ext_en;
                csr_rdata[BIT_TMR] = tmr_en;
            end
            SEL_FLAGS: begin
                csr_rdata[BIT_EXT] = ext_pend;
                csr_rdata[BIT_TMR] = timer_irq;
            end
            SEL_LEVEL:   csr_rdata = 32'(level);
            default:     csr_rdata = '0;
        endcase
    end
endmodule

// Checker: temporal properties of the controller, bound to every instance.
module ext_irq_ctrl_chk
    import ext_irq_pkg::*;
#(
    parameter int NUM_LINES = 32,
    parameter int LVL_W     = 5
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_LINES-1:0] irq_lines,
    input logic [NUM_LINES-1:0] pend_q,
    input logic                 found,
    input logic                 ext_pend,
    input logic                 irq_req,
    input logic                 mstatus_mie,
    input logic [2:0]           csr_sel,
    input logic [31:0]          csr_rdata,
    input logic                 trap_enter,
    input logic [31:0]          cause_code,
    input logic [LVL_W-1:0]     level
);
    a_r1_pend_follows: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> pend_q == $past(irq_lines));
    a_r5_pend_needs_winner: assert property (@(posedge clk) disable iff (!rst_n)
        ext_pend |-> found);
    a_r7_req_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> mstatus_mie);
    a_r2_next_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_sel == SEL_NEXT && found) |-> (csr_rdata[1:0] == 2'b00 && !csr_rdata[31]));
    a_r6_level_rises: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_enter && cause_code == CAUSE_EXTERNAL) |=> level > $past(level));
endmodule

bind ext_irq_ctrl ext_irq_ctrl_chk #(.NUM_LINES(NUM_LINES), .LVL_W(LVL_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .pend_q(pend_q), .found(found),
    .ext_pend(ext_pend), .irq_req(irq_req), .mstatus_mie(mstatus_mie),
    .csr_sel(csr_sel), .csr_rdata(csr_rdata), .trap_enter(trap_enter),
    .cause_code(cause_code), .level(level)
);

// File: tb/ext_irq_ctrl_tb_top.sv
// Bench: behavioural reference model compared every cycle, plus directed checks.
`timescale 1ns/100ps
module ext_irq_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_lines = '0;
    logic        timer_irq = 1'b0, mstatus_mie = 1'b0;
    logic        csr_en = 1'b0, csr_wr = 1'b0;
    logic [2:0]  csr_sel = '0;
    logic [4:0]  csr_idx = '0;
    logic [31:0] csr_wdata = '0, csr_rdata, cause_code;
    logic        trap_enter = 1'b0, trap_return = 1'b0;
    logic        irq_req, ext_pend;

    int n_checks = 0, n_errors = 0;
    bit done = 1'b0, compare_on = 1'b0;

    always #2 clk = ~clk;

    ext_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .timer_irq(timer_irq),
        .mstatus_mie(mstatus_mie), .csr_en(csr_en), .csr_wr(csr_wr), .csr_sel(csr_sel),
        .csr_idx(csr_idx), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .trap_enter(trap_enter), .trap_return(trap_return), .irq_req(irq_req),
        .cause_code(cause_code), .ext_pend(ext_pend)
    );

    // Reference model state
    bit [31:0] m_pend, m_en;
    int        m_prio [32];
    bit        m_eie, m_tie;
    int        m_level;
    int        m_stk [$];

    function automatic void check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endfunction

    function automatic void m_eval(output bit fnd, output int bidx, output bit meip,
                                   output bit req, output logic [31:0] cause,
                                   output logic [31:0] rd);
        int bp = 0;
        bit te, tt;
        fnd = 0; bidx = 0;
        for (int i = 0; i < 32; i++)
            if (m_pend[i] && m_en[i] && (!fnd || m_prio[i] > bp)) begin
                fnd = 1; bidx = i; bp = m_prio[i];
            end
        meip  = fnd && (bp + 1 > m_level);
        te    = meip && m_eie;
        tt    = timer_irq && m_tie;
        req   = mstatus_mie && (te || tt);
        cause = te ? 32'h8000_000B : (tt ? 32'h8000_0007 : 32'h0);
        case (csr_sel)
            3'd0: rd = (m_en >> (csr_idx[0] * 16)) & 32'hFFFF;
            3'd1: rd = (m_pend >> (csr_idx[0] * 16)) & 32'hFFFF;
            3'd2: rd = 32'(m_prio[csr_idx]);
            3'd3: rd = fnd ? 32'(bidx * 4) : 32'h8000_0000;
            3'd4: rd = (32'(m_eie) << 11) | (32'(m_tie) << 7);
            3'd5: rd = (32'(meip) << 11) | (32'(timer_irq) << 7);
            3'd6: rd = 32'(m_level);
            default: rd = 0;
        endcase
        if (te) m_level = m_level; // keeps lint quiet on unused path
        return;
        // bp used for push level in model_step
    endfunction

    function automatic int m_best_prio();
        int bp = -1;
        for (int i = 0; i < 32; i++)
            if (m_pend[i] && m_en[i] && m_prio[i] > bp) bp = m_prio[i];
        return bp;
    endfunction

    // Model state update on every rising edge.
    always @(posedge clk) begin
        bit fnd, meip, req; int bidx; logic [31:0] cause, rd;
        if (!rst_n) begin
            m_pend = 0; m_en = 0; m_eie = 0; m_tie = 0; m_level = 0; m_stk.delete();
            for (int i = 0; i < 32; i++) m_prio[i] = 0;
        end else begin
            m_eval(fnd, bidx, meip, req, cause, rd);
            if (trap_enter) begin
                if (m_stk.size() < 17) begin
                    m_stk.push_back(m_level);
                    if (cause == 32'h8000_000B) m_level = m_best_prio() + 1;
                end
            end else if (trap_return && m_stk.size() > 0) begin
                m_level = m_stk.pop_back();
            end
            if (csr_en && csr_wr) begin
                case (csr_sel)
                    3'd0: if (csr_idx[0]) m_en[31:16] = csr_wdata[15:0];
                          else            m_en[15:0]  = csr_wdata[15:0];
                    3'd2: m_prio[csr_idx] = int'(csr_wdata[3:0]);
                    3'd4: begin m_eie = csr_wdata[11]; m_tie = csr_wdata[7]; end
                    default: ;
                endcase
            end
            m_pend = irq_lines;
        end
    end

    // Every-cycle comparison of all outputs against the model.
    always @(negedge clk) begin
        bit fnd, meip, req; int bidx; logic [31:0] cause, rd;
        if (compare_on && !done) begin
            m_eval(fnd, bidx, meip, req, cause, rd);
            check(ext_pend == meip, "R5 model ext_pend", 32'(ext_pend), 32'(meip));
            check(irq_req == req, "R7 model irq_req", 32'(irq_req), 32'(req));
            check(cause_code == cause, "R7 model cause", cause_code, cause);
            check(csr_rdata == rd, "R1/R2 model rdata", csr_rdata, rd);
        end
    end

    task automatic tick(); @(posedge clk); #1; endtask

    task automatic reg_write(input logic [2:0] sel, input logic [4:0] idx, input logic [31:0] d);
        tick(); csr_en = 1; csr_wr = 1; csr_sel = sel; csr_idx = idx; csr_wdata = d;
        tick(); csr_en = 0; csr_wr = 0;
    endtask

    task automatic reg_read(input logic [2:0] sel, input logic [4:0] idx,
                            input logic [31:0] exp, input string tag);
        tick(); csr_en = 1; csr_wr = 0; csr_sel = sel; csr_idx = idx;
        #1 check(csr_rdata === exp, tag, csr_rdata, exp);
        csr_en = 0;
    endtask

    task automatic pulse_enter(); tick(); trap_enter = 1; tick(); trap_enter = 0; endtask
    task automatic pulse_return(); tick(); trap_return = 1; tick(); trap_return = 0; endtask

    task automatic wait_req();
        for (int w = 0; w < 20; w++) begin
            tick(); #1;
            if (irq_req) break;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual=%0d expected=0 cycles left", 0);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        compare_on = 1;
        // R4 R2 R8 R9: reset state
        reg_read(3'd0, 5'd0, 32'h0, "R4 enable idx0 after reset");
        reg_read(3'd0, 5'd1, 32'h0, "R4 enable idx1 after reset");
        reg_read(3'd3, 5'd0, 32'h8000_0000, "R2 next none after reset");
        reg_read(3'd4, 5'd0, 32'h0, "R8 local enable after reset");
        reg_read(3'd2, 5'd17, 32'h0, "R9 priority after reset");

        // All lines at equal priority, serviced one by one
        reg_write(3'd4, 5'd0, 32'h800);
        reg_read(3'd4, 5'd0, 32'h800, "R8 local enable readback");
        reg_write(3'd0, 5'd0, 32'hFFFF);
        reg_write(3'd0, 5'd1, 32'hFFFF);
        mstatus_mie = 1; timer_irq = 1;
        irq_lines = 32'hFFFF_FFFF;
        for (int k = 0; k < 32; k++) begin
            wait_req();
            check(irq_req && cause_code == 32'h8000_000B, "R7 external cause",
                  cause_code, 32'h8000_000B);
            pulse_enter();
            check(ext_pend == 1'b0, "R5 equal priority no preempt", 32'(ext_pend), 32'h0);
            reg_read(3'd5, 5'd0, 32'h80, "R8 flags show timer only");
            reg_read(3'd3, 5'd0, 32'(k * 4), "R2 R3 next in handler");
            reg_read(3'd1, 5'd1, 32'hFFFF & ~(32'hFFFF_FFFF >> (32 - k) << 16 >> 16 & 32'h0) & 32'(irq_lines[31:16]),
                     "R1 pending upper window");
            irq_lines[k] = 1'b0;
            tick(); tick();
            reg_read(3'd3, 5'd0, (k == 31) ? 32'h8000_0000 : 32'((k + 1) * 4),
                     "R2 next after line drop");
            pulse_return();
        end
        reg_read(3'd6, 5'd0, 32'h0, "R6 level idle after all returns");
        timer_irq = 0;

        // Mixed priorities, tie and nesting
        reg_write(3'd2, 5'd5, 32'd3);
        reg_write(3'd2, 5'd9, 32'd3);
        reg_write(3'd2, 5'd2, 32'd1);
        irq_lines = (32'd1 << 2) | (32'd1 << 5) | (32'd1 << 9);
        tick(); tick();
        reg_read(3'd3, 5'd0, 32'd20, "R3 tie resolves to lower line");
        wait_req();
        pulse_enter();
        reg_read(3'd6, 5'd0, 32'd4, "R6 level after entry");
        check(ext_pend == 1'b0, "R5 no preempt at equal level", 32'(ext_pend), 32'h0);
        reg_write(3'd2, 5'd20, 32'd7);
        irq_lines[20] = 1'b1;
        tick(); tick();
        check(ext_pend == 1'b1, "R5 higher priority preempts", 32'(ext_pend), 32'h1);
        reg_read(3'd3, 5'd0, 32'd80, "R3 higher priority wins");
        pulse_enter();
        reg_read(3'd6, 5'd0, 32'd8, "R6 nested level");
        check(ext_pend == 1'b0, "R5 no self preempt", 32'(ext_pend), 32'h0);
        pulse_return();
        reg_read(3'd6, 5'd0, 32'd4, "R6 level restored");
        check(ext_pend == 1'b1, "R5 preempt visible after restore", 32'(ext_pend), 32'h1);
        pulse_return();
        reg_read(3'd6, 5'd0, 32'd0, "R6 level idle");
        reg_read(3'd2, 5'd20, 32'd7, "R9 priority readback");

        // Pending writes have no effect
        irq_lines = 32'h0001_00F0;
        tick(); tick();
        reg_write(3'd1, 5'd0, 32'hFFFF);
        reg_read(3'd1, 5'd0, 32'h00F0, "R1 pending write ignored");
        reg_read(3'd1, 5'd1, 32'h0001, "R1 pending upper window");

        // Enable windows
        reg_write(3'd0, 5'd1, 32'h0);
        irq_lines = 32'd1 << 20;
        tick(); tick();
        reg_read(3'd3, 5'd0, 32'h8000_0000, "R4 upper window disabled");
        check(ext_pend == 1'b0, "R4 no pending when disabled", 32'(ext_pend), 32'h0);
        reg_write(3'd0, 5'd1, 32'h0010);
        reg_read(3'd3, 5'd0, 32'd80, "R4 enable takes effect next cycle");
        reg_read(3'd0, 5'd1, 32'h0010, "R4 enable window readback");

        // Timer cause and global gate
        irq_lines = 0;
        reg_write(3'd4, 5'd0, 32'h880);
        timer_irq = 1;
        tick(); tick();
        check(irq_req == 1'b1 && cause_code == 32'h8000_0007, "R7 timer cause",
              cause_code, 32'h8000_0007);
        mstatus_mie = 0;
        tick();
        check(irq_req == 1'b0, "R7 global gate", 32'(irq_req), 32'h0);
        irq_lines = 32'd1 << 20;
        mstatus_mie = 1;
        tick(); tick();
        check(cause_code == 32'h8000_000B, "R7 external beats timer", cause_code, 32'h8000_000B);
        tick();
        finish_run();
    end
endmodule